// File: doc/BRIEF.md
# Dual-Mode Watchdog Interval Timer

This block supervises software from a slow, free-running low-frequency clock that is independent of the bus clock. In watchdog mode it counts slow-clock ticks and emits a one-cycle system reset pulse if software does not service it before the chosen interval runs out. Servicing takes a two-step unlock: the clear field receives the arm code 0xA and then the kick code 0x5 within a short window. In timer mode the same counter acts as a repeating interval timer that sets a sticky interrupt flag at every expiry and never resets the system.

Software writes one control word (enable, mode, interval select, clear code, interrupt acknowledge) on the bus clock through a valid/ready write port. A toggle handshake moves each word into the slow-clock domain. While a word is in flight, `wr_ready` stays low, and the writer must hold off (back-pressure) until it returns high. A word is taken on a bus-clock edge where both `wr_valid` and `wr_ready` are high. A low-power input in the slow domain holds the counter at zero without touching the configuration.

Top module: `dual_wdog_timer`

## Requirements
- R1: After reset the block is disabled: `sys_rst_pulse` and `irq_flag` are low, `wr_ready` is high, and no reset pulse or interrupt occurs until an enabling write arrives.
- R2: Each accepted write drops `wr_ready` until the slow domain has applied it. While `wr_ready` is low the captured word stays stable, and each accepted word is applied exactly once.
- R3: Interval select values 0, 1, 2, 3 choose a terminal count of 2^EXP0, 2^EXP1, 2^EXP2, 2^EXP3 slow ticks (default 64, 512, 8192, 32768). A free-running watchdog fires once every terminal count of slow edges.
- R4: Mode bit 0 selects watchdog mode and 1 selects timer mode. A write that takes enable from 0 to 1 restarts the counter from zero.
- R5: While enabled in watchdog mode, writes cannot clear enable or change the mode, but they do change the interval select.
- R6: In watchdog mode, clear field 0xA followed by 0x5 applied within WIN_EDGES slow edges restarts the counter from zero.
- R7: A write after 0xA whose clear field is anything other than 0x5, or a 0x5 that comes later than the window, does not restart the counter. The sequence must begin again with 0xA.
- R8: In watchdog mode, expiry produces a `sys_rst_pulse` exactly one slow cycle wide and never sets `irq_flag`.
- R9: In timer mode, expiry sets `irq_flag` and never pulses the reset. The flag stays high until a write with the interrupt acknowledge bit set.
- R10: In timer mode, a write with bit 0 of the clear field set restarts the counter from zero.
- R11: In timer mode, enable 0 stops the counter, and the mode bit may be changed freely.
- R12: While `low_power` is high, the counter is held at zero and no event occurs. On release, counting restarts from zero with the enable, mode and interval settings kept as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| wr_valid | input | 1 | Control word write request |
| wr_ready | output | 1 | Write port can take a word |
| wr_enable | input | 1 | Enable field |
| wr_mode | input | 1 | Mode field: 0 watchdog, 1 timer |
| wr_interval | input | 2 | Interval select field |
| wr_clear | input | 4 | Clear / service code field |
| wr_irq_ack | input | 1 | Acknowledge: clears the interrupt flag |
| slow_clk | input | 1 | Independent low-frequency counting clock |
| slow_rst_n | input | 1 | Active-low asynchronous reset, slow domain |
| low_power | input | 1 | Deep power mode entry, slow domain |
| sys_rst_pulse | output | 1 | One-cycle system reset request, slow domain |
| irq_flag | output | 1 | Sticky interval interrupt flag, slow domain |

## Verification
A counter that is wrong inside the block shows up as the spacing between reset pulses or interrupt rises. The bench measures that spacing in slow edges, so a fault appears at the next expiry, at most one terminal count later. A broken service sequencer is seen as a missing pulse, or as a pulse in the wrong place, during the pulse window that follows a sequence that was valid, aborted or late. A lock or low-power state that is wrong is exposed within one interval, because pulses either stop or keep coming when they should not.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef struct packed {
    logic       en;
    logic       mode;
    logic [1:0] ivl;
    logic [3:0] clr;
    logic       irq_ack;
  } wdt_word_t;

  localparam logic       MODE_WDOG = 1'b0;
  localparam logic       MODE_TMR  = 1'b1;
  localparam logic [3:0] CODE_ARM  = 4'hA;
  localparam logic [3:0] CODE_KICK = 4'h5;
endpackage

// File: rtl/wdt_word_sync.sv
module wdt_word_sync
  import wdt_pkg::*;
(
  input  logic      bus_clk,
  input  logic      bus_rst_n,
  input  logic      wr_valid,
  output logic      wr_ready,
  input  wdt_word_t wr_word,
  input  logic      slow_clk,
  input  logic      slow_rst_n,
  output logic      word_stb,
  output wdt_word_t word_out
);
  logic      req_tgl, ack_b1, ack_b2;
  wdt_word_t held;
  logic      req_s1, req_s2, req_s3;

  assign wr_ready = (req_tgl == ack_b2);

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      req_tgl <= 1'b0;
      held    <= '0;
      ack_b1  <= 1'b0;
      ack_b2  <= 1'b0;
    end else begin
      ack_b1 <= req_s3;
      ack_b2 <= ack_b1;
      if (wr_valid && wr_ready) begin
        held    <= wr_word;
        req_tgl <= ~req_tgl;
      end
    end
  end

  always_ff @(posedge slow_clk or negedge slow_rst_n) begin
    if (!slow_rst_n) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
      req_s3 <= 1'b0;
    end else begin
      req_s1 <= req_tgl;
      req_s2 <= req_s1;
      req_s3 <= req_s2;
    end
  end

  assign word_stb = req_s2 ^ req_s3;
  assign word_out = held;

  // R2
  busy_hold_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    !wr_ready |=> $stable(held));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int WIN_EDGES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stb,
  input  wdt_word_t  d,
  output logic       en_q,
  output logic       mode_q,
  output logic [1:0] ivl_q,
  output logic       restart,
  output logic       irq_ack
);
  localparam int WIN_W = $clog2(WIN_EDGES + 1);

  logic             locked, new_en, new_mode;
  logic             armed;
  logic [WIN_W-1:0] win;
  logic             start, tmr_clr, kick;

  assign locked   = en_q && (mode_q == MODE_WDOG);
  assign new_en   = locked ? 1'b1 : d.en;
  assign new_mode = locked ? MODE_WDOG : d.mode;

  assign start   = stb && !en_q && d.en;
  assign tmr_clr = stb && (new_mode == MODE_TMR) && d.clr[0];
  assign kick    = stb && (new_mode == MODE_WDOG) && armed &&
                   (d.clr == CODE_KICK) && (win != '0);
  assign restart = start || tmr_clr || kick;
  assign irq_ack = stb && d.irq_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= MODE_WDOG;
      ivl_q  <= 2'd0;
    end else if (stb) begin
      en_q   <= new_en;
      mode_q <= new_mode;
      ivl_q  <= d.ivl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      win   <= '0;
    end else if (stb) begin
      if ((new_mode == MODE_WDOG) && (d.clr == CODE_ARM)) begin
        armed <= 1'b1;
        win   <= WIN_W'(WIN_EDGES);
      end else begin
        armed <= 1'b0;
      end
    end else if (armed) begin
      if (win == '0) armed <= 1'b0;
      else           win   <= win - 1'b1;
    end
  end

  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && mode_q == MODE_WDOG) |=> (en_q && mode_q == MODE_WDOG));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CNT_W = 15,
  parameter int EXP0  = 6,
  parameter int EXP1  = 9,
  parameter int EXP2  = 13,
  parameter int EXP3  = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       mode,
  input  logic [1:0] ivl,
  input  logic       restart,
  input  logic       irq_ack,
  input  logic       low_power,
  output logic       rst_pulse,
  output logic       irq
);
  localparam int EXPS [4] = '{EXP0, EXP1, EXP2, EXP3};

  logic [CNT_W-1:0] lim [4];
  logic [CNT_W-1:0] cnt;
  logic             hit;

  for (genvar i = 0; i < 4; i++) begin : g_lim
    assign lim[i] = CNT_W'((64'd1 << EXPS[i]) - 64'd1);
  end

  assign hit = en && (cnt >= lim[ivl]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      rst_pulse <= 1'b0;
      irq       <= 1'b0;
    end else begin
      rst_pulse <= 1'b0;
      if (irq_ack) irq <= 1'b0;
      if (low_power || restart) begin
        cnt <= '0;
      end else if (en) begin
        if (hit) begin
          cnt <= '0;
          if (mode == MODE_TMR) irq <= 1'b1;
          else                  rst_pulse <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R8
  rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);
  // R8
  irq_wdog_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(mode) == MODE_TMR);
  // R12
  lp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |=> (cnt == '0 && !rst_pulse));
  // R4
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt == '0);
endmodule

// File: rtl/dual_wdog_timer.sv
module dual_wdog_timer
  import wdt_pkg::*;
#(
  parameter int CNT_W     = 15,
  parameter int EXP0      = 6,
  parameter int EXP1      = 9,
  parameter int EXP2      = 13,
  parameter int EXP3      = 15,
  parameter int WIN_EDGES = 8
) (
  input  logic       bus_clk,
  input  logic       bus_rst_n,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic       wr_enable,
  input  logic       wr_mode,
  input  logic [1:0] wr_interval,
  input  logic [3:0] wr_clear,
  input  logic       wr_irq_ack,
  input  logic       slow_clk,
  input  logic       slow_rst_n,
  input  logic       low_power,
  output logic       sys_rst_pulse,
  output logic       irq_flag
);
  wdt_word_t  in_word, s_word;
  logic       s_stb, en_q, mode_q, restart, irq_ack;
  logic [1:0] ivl_q;

  assign in_word = '{en: wr_enable, mode: wr_mode, ivl: wr_interval,
                     clr: wr_clear, irq_ack: wr_irq_ack};

  wdt_word_sync u_sync (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_word(in_word), .slow_clk(slow_clk),
    .slow_rst_n(slow_rst_n), .word_stb(s_stb), .word_out(s_word));

  wdt_ctrl #(.WIN_EDGES(WIN_EDGES)) u_ctrl (
    .clk(slow_clk), .rst_n(slow_rst_n), .stb(s_stb), .d(s_word),
    .en_q(en_q), .mode_q(mode_q), .ivl_q(ivl_q), .restart(restart),
    .irq_ack(irq_ack));

  wdt_counter #(.CNT_W(CNT_W), .EXP0(EXP0), .EXP1(EXP1), .EXP2(EXP2),
                .EXP3(EXP3)) u_cnt (
    .clk(slow_clk), .rst_n(slow_rst_n), .en(en_q), .mode(mode_q),
    .ivl(ivl_q), .restart(restart), .irq_ack(irq_ack),
    .low_power(low_power), .rst_pulse(sys_rst_pulse), .irq(irq_flag));
endmodule

// File: tb/dual_wdog_timer_tb.sv
module dual_wdog_timer_tb;
  logic bus_clk = 0, slow_clk = 0;
  logic bus_rst_n = 0, slow_rst_n = 0;
  logic wr_valid = 0, wr_enable = 0, wr_mode = 0, wr_irq_ack = 0;
  logic [1:0] wr_interval = 0;
  logic [3:0] wr_clear = 0;
  logic low_power = 0;
  logic wr_ready, sys_rst_pulse, irq_flag;

  int checks = 0, errors = 0;
  int sedge = 0, cyc = 0;
  int pulse_cnt = 0, irq_rises = 0, last_irq_rise = 0;
  int ref_edge = 0;
  bit ref_valid = 0, prev_p = 0, prev_irq = 0;
  int exp_q[$];
  string exp_tag[$];
  logic [1:0] cur_ivl = 0;

  always #5 bus_clk = ~bus_clk;
  initial begin #3; forever #40 slow_clk = ~slow_clk; end

  dual_wdog_timer #(.CNT_W(5), .EXP0(2), .EXP1(3), .EXP2(4), .EXP3(5),
                    .WIN_EDGES(8)) u_dut (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_enable(wr_enable), .wr_mode(wr_mode),
    .wr_interval(wr_interval), .wr_clear(wr_clear), .wr_irq_ack(wr_irq_ack),
    .slow_clk(slow_clk), .slow_rst_n(slow_rst_n), .low_power(low_power),
    .sys_rst_pulse(sys_rst_pulse), .irq_flag(irq_flag));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge bus_clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  always @(posedge slow_clk) sedge++;

  // monitor: pulse spacing scoreboard, pulse width, irq rises
  always @(negedge slow_clk) begin
    if (sys_rst_pulse) begin
      chk(!prev_p, "R8 width", 2, 1);
      pulse_cnt++;
      if (ref_valid && exp_q.size() != 0) begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        chk(sedge - ref_edge == e, t, sedge - ref_edge, e);
      end
      ref_edge  = sedge;
      ref_valid = 1;
    end
    if (irq_flag && !prev_irq) begin
      irq_rises++;
      last_irq_rise = sedge;
    end
    prev_p   = sys_rst_pulse;
    prev_irq = irq_flag;
  end

  task automatic bw(input bit en, input bit mode, input logic [1:0] ivl,
                    input logic [3:0] clr, input bit ack);
    @(negedge bus_clk);
    while (!wr_ready) @(negedge bus_clk);
    wr_valid = 1; wr_enable = en; wr_mode = mode; wr_interval = ivl;
    wr_clear = clr; wr_irq_ack = ack;
    @(negedge bus_clk);
    wr_valid = 0;
  endtask

  task automatic push(input int gap, input int n, input string tag);
    for (int i = 0; i < n; i++) begin exp_q.push_back(gap); exp_tag.push_back(tag); end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge slow_clk);
  endtask

  task automatic wait_pulse();
    int c = pulse_cnt;
    while (pulse_cnt == c) @(negedge slow_clk);
  endtask

  task automatic wait_irq();
    int c = irq_rises;
    while (irq_rises == c) @(negedge slow_clk);
  endtask

  task automatic do_reset();
    @(negedge bus_clk);
    bus_rst_n = 0; slow_rst_n = 0;
    repeat (3) @(negedge slow_clk);
    bus_rst_n = 1; slow_rst_n = 1;
    ref_valid = 0;
    @(negedge slow_clk);
  endtask

  initial begin
    int p0, r1, r2;
    do_reset();
    // R1 reset state and inactivity
    chk(sys_rst_pulse == 0, "R1 rst", sys_rst_pulse, 0);
    chk(irq_flag == 0, "R1 irq", irq_flag, 0);
    chk(wr_ready == 1, "R1 ready", wr_ready, 1);
    repeat (60) @(negedge slow_clk);
    chk(pulse_cnt == 0, "R1 idle", pulse_cnt, 0);

    // R2: ready drops after an accepted write
    bw(1, 0, 0, 0, 0);
    chk(wr_ready == 0, "R2 busy", wr_ready, 0);
    // R3 R4 R8: watchdog interval 0 -> 4 edges
    push(4, 3, "R3 gap ivl0");
    drain();
    // R5: interval still writable under lock
    bw(1, 0, 2, 0, 0); cur_ivl = 2;
    wait_pulse(); ref_valid = 0;
    push(16, 2, "R5 gap ivl2");
    drain();
    // R5: enable 0 / mode 1 ignored once locked
    bw(0, 1, 2, 0, 0);
    push(16, 2, "R5 lock");
    drain();
    chk(irq_flag == 0, "R8 no irq", irq_flag, 0);
    bw(1, 0, 3, 0, 0); cur_ivl = 3;
    wait_pulse(); ref_valid = 0;
    push(32, 1, "R3 gap ivl3");
    drain();

    // R6: regular service keeps reset away
    wait_pulse();
    p0 = pulse_cnt;
    for (int i = 0; i < 25; i++) begin
      bw(1, 0, cur_ivl, 4'hA, 0);
      bw(1, 0, cur_ivl, 4'h5, 0);
      repeat (4) @(negedge slow_clk);
    end
    chk(pulse_cnt == p0, "R6 serviced", pulse_cnt - p0, 0);

    // R7: aborted sequence A,3,5 does not restart
    wait_pulse();
    bw(1, 0, cur_ivl, 4'hA, 0);
    bw(1, 0, cur_ivl, 4'h3, 0);
    bw(1, 0, cur_ivl, 4'h5, 0);
    push(32, 1, "R7 abort");
    drain();
    // R7: late second code
    wait_pulse();
    bw(1, 0, cur_ivl, 4'hA, 0);
    repeat (16) @(negedge slow_clk);
    bw(1, 0, cur_ivl, 4'h5, 0);
    push(32, 1, "R7 late");
    drain();

    // R12: low power hold and restart, config kept
    bw(1, 0, 0, 0, 0); cur_ivl = 0;
    repeat (10) @(negedge slow_clk);
    low_power = 1;
    p0 = pulse_cnt;
    repeat (50) @(negedge slow_clk);
    chk(pulse_cnt == p0, "R12 held", pulse_cnt - p0, 0);
    low_power = 0; ref_edge = sedge; ref_valid = 1;
    push(4, 2, "R12 resume");
    drain();

    // timer mode
    do_reset();
    chk(sys_rst_pulse == 0 && irq_flag == 0, "R1 rst2", irq_flag, 0);
    p0 = pulse_cnt;
    bw(1, 1, 1, 0, 0);
    wait_irq(); r1 = last_irq_rise;
    repeat (40) @(negedge slow_clk);
    chk(irq_flag == 1, "R9 sticky", irq_flag, 1);
    bw(1, 1, 1, 0, 1);
    repeat (2) @(negedge slow_clk);
    wait_irq(); r2 = last_irq_rise;
    chk((r2 - r1) % 8 == 0, "R9 period", (r2 - r1) % 8, 0);
    chk(pulse_cnt == p0, "R9 no reset", pulse_cnt - p0, 0);

    // R10: repeated bit0 clears prevent expiry
    bw(1, 1, 3, 4'h1, 1);
    for (int i = 0; i < 30; i++) begin
      bw(1, 1, 3, 4'h1, 0);
      repeat (2) @(negedge slow_clk);
    end
    chk(irq_flag == 0, "R10 clear", irq_flag, 0);
    repeat (45) @(negedge slow_clk);
    chk(irq_flag == 1, "R9 expiry", irq_flag, 1);

    // R11: stop, then switch mode freely
    bw(0, 1, 3, 0, 1);
    repeat (100) @(negedge slow_clk);
    chk(irq_flag == 0, "R11 stopped", irq_flag, 0);
    bw(1, 0, 0, 0, 0);
    ref_valid = 0;
    push(4, 2, "R11 mode switch");
    drain();

    finish_run();
  end
endmodule